// File: doc/BRIEF.md
# Four-Phase Cross-Clock Command Link

This block carries a single command and an optional data word from one clock domain to another. It uses a fully interlocked request/acknowledge exchange. Local logic on the sending side pulses a start input together with a data word. The link then raises an internal request line and reports busy while the exchange runs. It gives a one-cycle done pulse once the exchange has completed.

On the receiving side, the request is seen through a two-flop synchronizer. The link then emits a one-cycle action strobe carrying the captured word and raises an acknowledge line, which is synchronized back in the same way. Each phase waits on the other side's settled level: request up, acknowledge up, request down, acknowledge down. Because of this, the strobe fires once per accepted request whatever the ratio of the two clock rates.

Only the single-bit request and acknowledge lines cross domains through synchronizers. The data word is latched on the sending side and held unchanged for the whole exchange. The receiver samples it only after it sees the request high.

Top module: `hs4_link`

## Requirements
- R1: While either reset is low (asynchronous, active-low), `s_busy`, `s_done` and `r_fire` read 0; after both resets release with no start, they stay 0.
- R2: A `s_start` pulse sampled while `s_busy` is 0 makes `s_busy` read 1 from the next sender clock cycle.
- R3: A `s_start` pulse sampled while `s_busy` is 1 has no effect: it produces no extra strobe and its data word never appears on `r_data`.
- R4: Each accepted request produces exactly one `r_fire` strobe, and it does so for receiver clocks faster than, equal to and slower than the sender clock. The strobe has already occurred when `s_done` rises.
- R5: On the cycle `r_fire` is 1, `r_data` equals the `s_data` value sampled with the accepting start pulse. Strobes arrive in request order.
- R6: `r_fire` is never high for two consecutive receiver clock cycles.
- R7: `s_done` is a one-cycle pulse. In the cycle it reads 1, `s_busy` reads 0, and `s_busy` falls only together with `s_done`.
- R8: The sender holds the data word it launched unchanged from the accepting start until `s_busy` falls.
- R9: A start pulse in the same cycle that `s_done` reads 1 is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s_clk | input | 1 | Sender clock |
| s_rst_n | input | 1 | Sender asynchronous active-low reset |
| s_start | input | 1 | Start pulse, honoured only when idle |
| s_data | input | DW | Data word sampled with an accepted start |
| s_busy | output | 1 | Exchange in progress |
| s_done | output | 1 | One-cycle completion pulse |
| r_clk | input | 1 | Receiver clock |
| r_rst_n | input | 1 | Receiver asynchronous active-low reset |
| r_fire | output | 1 | One-cycle action strobe |
| r_data | output | DW | Word delivered with the strobe |

## Verification
A stuck or mis-sequenced phase register shows up at the ports in one of three ways. The link may hang busy, it may give a done pulse before the strobe has fired, or it may fire twice per request. Each of these is visible within a few synchronizer delays of the faulty phase, which is at most tens of cycles of the slower clock. A data latch that is not held shows up as a wrong word on the strobe of the very request it belongs to. Running the same requests under receiver clocks slower and faster than the sender clock exposes any phase that relies on a sampled pulse instead of a settled level.

// File: rtl/hs4_link.sv
module hs4_link #(
  parameter int DW = 8
) (
  input  logic          s_clk,
  input  logic          s_rst_n,
  input  logic          s_start,
  input  logic [DW-1:0] s_data,
  output logic          s_busy,
  output logic          s_done,
  input  logic          r_clk,
  input  logic          r_rst_n,
  output logic          r_fire,
  output logic [DW-1:0] r_data
);

  logic          req, ack;
  logic [1:0]    ack_sy, req_sy;
  logic [DW-1:0] hold;
  logic          ack_s, req_r;

  assign ack_s = ack_sy[1];
  assign req_r = req_sy[1];

  // sender domain
  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      ack_sy <= '0;
      req    <= 1'b0;
      s_busy <= 1'b0;
      s_done <= 1'b0;
      hold   <= '0;
    end else begin
      ack_sy <= {ack_sy[0], ack};
      s_done <= 1'b0;
      if (!s_busy) begin
        if (s_start) begin
          req    <= 1'b1;
          s_busy <= 1'b1;
          hold   <= s_data;
        end
      end else if (req) begin
        if (ack_s) req <= 1'b0;
      end else if (!ack_s) begin
        s_busy <= 1'b0;
        s_done <= 1'b1;
      end
    end
  end

  // receiver domain
  always_ff @(posedge r_clk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      req_sy <= '0;
      ack    <= 1'b0;
      r_fire <= 1'b0;
      r_data <= '0;
    end else begin
      req_sy <= {req_sy[0], req};
      r_fire <= 1'b0;
      if (!ack) begin
        if (req_r) begin
          ack    <= 1'b1;
          r_fire <= 1'b1;
          r_data <= hold;
        end
      end else if (!req_r) begin
        ack <= 1'b0;
      end
    end
  end

  a_r2_req_in_busy: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    req |-> s_busy);
  a_r7_done_single: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_done |=> !s_done);
  a_r7_busy_fall_done: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $fell(s_busy) |-> s_done);
  a_r8_hold_stable: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_busy && $past(s_busy)) |-> $stable(hold));
  a_r6_fire_single: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    r_fire |=> !r_fire);
  a_r4_fire_on_ack_rise: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    r_fire |-> $rose(ack));

endmodule

// File: tb/tb_hs4_link.sv
`timescale 1ns/1ps
module tb_hs4_link;
  localparam int DW = 8;

  logic s_clk = 0, r_clk = 0, s_rst_n = 0, r_rst_n = 0;
  logic s_start = 0;
  logic [DW-1:0] s_data = '0;
  logic s_busy, s_done, r_fire;
  logic [DW-1:0] r_data;
  real r_half = 5.0;

  int checks = 0, errors = 0;
  int n_req = 0, n_fire = 0;
  logic prev_fire = 0;
  logic [DW-1:0] exp_q [0:511];
  int cyc = 0;

  hs4_link #(.DW(DW)) dut (.*);

  always #5 s_clk = ~s_clk;
  always #(r_half) r_clk = ~r_clk;

  function automatic logic [DW-1:0] pick_word(int i);
    return DW'(($urandom ^ (i * 37)) & ((1 << DW) - 1));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // receiver monitor: R4, R5, R6
  always @(negedge r_clk) begin
    if (r_rst_n) begin
      if (r_fire) begin
        check(n_fire < n_req, "R4 strobe without pending request", n_fire, n_req);
        check(r_data == exp_q[n_fire], "R5 strobe data", r_data, exp_q[n_fire]);
        n_fire++;
      end
      if (r_fire && prev_fire) check(0, "R6 strobe two cycles", 1, 0);
      prev_fire = r_fire;
    end
  end

  always @(posedge s_clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // one request; optionally pokes a start while busy (R3)
  task automatic do_req(logic [DW-1:0] w, bit poke, bit at_done);
    if (!at_done) @(negedge s_clk);
    s_start = 1; s_data = w;
    exp_q[n_req] = w; n_req++;
    @(negedge s_clk);
    s_start = 0; s_data = ~w;
    check(s_busy == 1, "R2 busy after start", s_busy, 1);
    if (poke) begin
      repeat (2) @(negedge s_clk);
      s_start = 1; s_data = w ^ 8'h5A;
      @(negedge s_clk);
      s_start = 0;
    end
    while (!s_done) @(negedge s_clk);
    check(s_busy == 0, "R7 busy low with done", s_busy, 0);
    check(n_fire == n_req, "R4 one strobe per request at done", n_fire, n_req);
  endtask

  initial begin
    void'($urandom(32'd42));
    #1;
    check(s_busy == 0 && s_done == 0 && r_fire == 0, "R1 reset outputs",
          {s_busy, s_done, r_fire}, 0);
    #30 s_rst_n = 1;
    #17 r_rst_n = 1;
    repeat (10) @(negedge s_clk);
    check(s_busy == 0 && s_done == 0 && n_fire == 0, "R1 idle after reset",
          {s_busy, s_done}, 0);

    for (int ph = 0; ph < 4; ph++) begin
      case (ph)
        0: r_half = 5.0;
        1: r_half = 17.0;
        2: r_half = 1.7;
        default: r_half = 7.3;
      endcase
      repeat (3) @(negedge s_clk);
      for (int i = 0; i < 12; i++) begin
        logic [DW-1:0] w;
        w = pick_word(i + ph * 100);
        if (i == 0) w = '0;
        if (i == 1) w = '1;
        do_req(w, ($urandom % 3) == 0, 0);
        @(negedge s_clk);
        check(s_done == 0, "R7 done single cycle", s_done, 0);
        repeat ($urandom % 4) @(negedge s_clk);
      end
    end

    // R9: start on the done cycle, back to back
    r_half = 3.1;
    do_req(8'hA5, 0, 0);
    do_req(8'h3C, 0, 1);
    do_req(8'hC3, 1, 1);
    @(negedge s_clk);
    check(s_busy == 0, "R9 back-to-back finished idle", s_busy, 0);

    repeat (60) @(negedge s_clk);
    check(n_fire == n_req, "R3 no strobe from ignored starts", n_fire, n_req);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule